// File: doc/BRIEF.md
# Branch Condition Flag Unit

This block keeps the three arithmetic status flags of a small processor core (zero, carry, negative) and decides, for a 5-bit condition field from the instruction decoder, whether a conditional branch is taken. The flags are loaded either by the ALU after an instruction that sets flags, or by a host write of the whole flags word. The block also assembles that word for host readback. The bit positions of the three flags within the word are fixed, so host software can save and restore them.

The take-branch decision is purely combinational from the stored flags and the condition field. The decoder can therefore read it in the same cycle as it presents the field. Bit 4 of the field picks the flag that bits 2 and 3 test: the carry flag or the negative flag. A single field can thus express tests on zero, tests on carry or negative, or both at once. The other bits of the host word that are not flags are kept as plain storage and read back unchanged, except for a fixed range that always reads as zero.

Top module: `ccf_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, all flags and all stored word bits clear, so flags_rdata reads 0 after reset.
- R2: When alu_flag_we is high at a rising edge, Z, C and N take the values of alu_z, alu_c and alu_n. They are visible on flags_rdata in the cycle after that edge.
- R3: When host_flag_we is high and alu_flag_we is low at a rising edge, Z, C and N load from host_flag_wdata bits 0, 1 and 2.
- R4: When both write enables are high at the same edge, the ALU values win for Z, C and N.
- R5: With neither write enable high, Z, C and N keep their values.
- R6: On flags_rdata, Z is bit 0, C is bit 1 and N is bit 2, and bits 9 to 13 always read as zero.
- R7: Every word bit above bit 2 and outside bits 9 to 13 reads back the value of the last host write, including a host write in the same cycle as an ALU update. ALU updates leave these bits unchanged.
- R8: Condition bit 0 set demands Z = 0, and condition bit 1 set demands Z = 1.
- R9: Condition bit 2 set demands the selected flag to be 0, and condition bit 3 set demands it to be 1. The selected flag is C when condition bit 4 is 0 and N when it is 1.
- R10: branch_take is 1 exactly when every demand selected by the field is met. A field with bits 0 to 3 all clear always gives 1, and a field with contradictory demands gives 0.
- R11: branch_take follows the stored flags and cond_code with no register in between. A flag change is reflected in the cycle after the edge that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_flag_we | input | 1 | Load flags from the ALU results |
| alu_z | input | 1 | ALU zero result |
| alu_c | input | 1 | ALU carry result |
| alu_n | input | 1 | ALU negative result |
| host_flag_we | input | 1 | Host write of the flags word |
| host_flag_wdata | input | WORD_W (32) | Host flags word |
| cond_code | input | 5 | Branch condition field |
| branch_take | output | 1 | Branch is taken |
| flags_rdata | output | WORD_W (32) | Packed flags word for readback |

## Verification
A full sweep of all 32 condition codes is run against all eight flag combinations. This separates a wrong polarity on a zero test, a swapped carry and negative selection under bit 4, and a missing AND between the zero and carry/negative halves. Directed cycles with both write enables high show whether the ALU wins for the flags while the host still owns the upper bits. Long random runs mix ALU writes, host writes and idle cycles with random condition codes. They separate a flag that fails to hold from a storage bit that an ALU update disturbs, and they keep bits 9 to 13 reading zero whatever data is written there.

// File: rtl/ccf_pkg.sv
// Package: shared flag type and bit positions for the branch condition unit.
// Assumes the three flags sit in the lowest word bits in the order Z, C, N.
package ccf_pkg;

    localparam int COND_W     = 5;
    localparam int FLAG_Z_BIT = 0;
    localparam int FLAG_C_BIT = 1;
    localparam int FLAG_N_BIT = 2;
    localparam int NUM_FLAGS  = 3;

    // Packed so that bit 0 is Z, bit 1 is C and bit 2 is N.
    typedef struct packed {
        logic n;
        logic c;
        logic z;
    } flags_t;

    // Index of each demand term inside the condition evaluator.
    localparam int DEM_Z_CLR   = 0;
    localparam int DEM_Z_SET   = 1;
    localparam int DEM_SEL_CLR = 2;
    localparam int DEM_SEL_SET = 3;
    localparam int SEL_BIT     = 4;

endpackage

// File: rtl/ccf_flag_store.sv
// Module: holds the Z, C and N flags.
// Loads from the ALU or from the host, and the ALU has priority when both write.
// Assumes a synchronous active-low reset that clears all flags.
module ccf_flag_store
    import ccf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   alu_we,
    input  flags_t alu_flags,
    input  logic   host_we,
    input  flags_t host_flags,
    output flags_t flags_q
);

    // Flag register with ALU-over-host write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (alu_we) begin
            flags_q <= alu_flags;
        end else if (host_we) begin
            flags_q <= host_flags;
        end
    end

endmodule

// File: rtl/ccf_cond_eval.sv
// Module: combinational branch decision.
// Every set bit of the condition field adds one demand on the flags, and the
// branch is taken only when all selected demands are met. Bit 4 chooses
// whether bits 2 and 3 test carry or negative.
module ccf_cond_eval
    import ccf_pkg::*;
(
    input  logic [COND_W-1:0] cond,
    input  flags_t            flags,
    output logic              take
);

    localparam int NUM_DEM = COND_W - 1;

    logic              sel_flag;
    logic [NUM_DEM-1:0] dem_ok;
    logic [NUM_DEM-1:0] dem_val;

    // Choose the flag tested by the carry/negative demands.
    always_comb begin
        sel_flag = cond[SEL_BIT] ? flags.n : flags.c;
    end

    // The flag value each demand bit expects to see.
    always_comb begin
        dem_val[DEM_Z_CLR]   = ~flags.z;
        dem_val[DEM_Z_SET]   = flags.z;
        dem_val[DEM_SEL_CLR] = ~sel_flag;
        dem_val[DEM_SEL_SET] = sel_flag;
    end

    // A demand that is not selected is always satisfied.
    for (genvar i = 0; i < NUM_DEM; i++) begin : g_dem
        assign dem_ok[i] = ~cond[i] | dem_val[i];
    end

    // Branch is taken only when every demand holds.
    always_comb begin
        take = &dem_ok;
    end

endmodule

// File: rtl/ccf_word_pack.sv
// Module: builds the readback word.
// Flags go into the low bits, a fixed range reads as zero, and every other
// bit is a storage flop loaded only by host writes.
// Assumes NUM_FLAGS < CLR_LO <= CLR_HI < WORD_W.
module ccf_word_pack
    import ccf_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CLR_LO = 9,
    parameter int CLR_HI = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WORD_W-1:0] host_wdata,
    input  flags_t            flags,
    output logic [WORD_W-1:0] word
);

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i < NUM_FLAGS) begin : g_flag
            assign word[i] = flags[i];
        end else if (i >= CLR_LO && i <= CLR_HI) begin : g_zero
            assign word[i] = 1'b0;
        end else begin : g_keep
            logic keep_q;
            // Plain storage bit owned by the host.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    keep_q <= 1'b0;
                end else if (host_we) begin
                    keep_q <= host_wdata[i];
                end
            end
            assign word[i] = keep_q;
        end
    end

endmodule

// File: rtl/ccf_unit.sv
// Module: branch condition flag unit (top).
// Stores Z/C/N, evaluates the 5-bit branch condition field against them, and
// packs the flags word for host readback.
// Assumes WORD_W covers the zero range and that reset is synchronous, active low.
module ccf_unit
    import ccf_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CLR_LO = 9,
    parameter int CLR_HI = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_flag_we,
    input  logic              alu_z,
    input  logic              alu_c,
    input  logic              alu_n,
    input  logic              host_flag_we,
    input  logic [WORD_W-1:0] host_flag_wdata,
    input  logic [COND_W-1:0] cond_code,
    output logic              branch_take,
    output logic [WORD_W-1:0] flags_rdata
);

    flags_t alu_flags;
    flags_t host_flags;
    flags_t flags_q;
    logic   unused_clr_bits;

    // Gather the ALU results and the host flag bits into the flag type.
    always_comb begin
        alu_flags  = '{n: alu_n, c: alu_c, z: alu_z};
        host_flags = '{n: host_flag_wdata[FLAG_N_BIT],
                       c: host_flag_wdata[FLAG_C_BIT],
                       z: host_flag_wdata[FLAG_Z_BIT]};
    end

    // Written data in the zero range is discarded.
    assign unused_clr_bits = ^host_flag_wdata[CLR_HI:CLR_LO];

    ccf_flag_store u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alu_we     (alu_flag_we),
        .alu_flags  (alu_flags),
        .host_we    (host_flag_we),
        .host_flags (host_flags),
        .flags_q    (flags_q)
    );

    ccf_cond_eval u_eval (
        .cond  (cond_code),
        .flags (flags_q),
        .take  (branch_take)
    );

    ccf_word_pack #(
        .WORD_W (WORD_W),
        .CLR_LO (CLR_LO),
        .CLR_HI (CLR_HI)
    ) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_flag_we),
        .host_wdata (host_flag_wdata),
        .flags      (flags_q),
        .word       (flags_rdata)
    );

endmodule

// File: rtl/ccf_unit_chk.sv
// Checker: temporal properties of ccf_unit, bound to every instance.
module ccf_unit_chk
    import ccf_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CLR_LO = 9,
    parameter int CLR_HI = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alu_flag_we,
    input logic              alu_z,
    input logic              alu_c,
    input logic              alu_n,
    input logic              host_flag_we,
    input logic [WORD_W-1:0] host_flag_wdata,
    input logic [COND_W-1:0] cond_code,
    input logic              branch_take,
    input logic [WORD_W-1:0] flags_rdata
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> flags_rdata == '0);

    // R2 R4
    alu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_flag_we |=> flags_rdata[2:0] == $past({alu_n, alu_c, alu_z}));

    // R3
    host_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_flag_we && !alu_flag_we) |=> flags_rdata[2:0] == $past(host_flag_wdata[2:0]));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_flag_we && !alu_flag_we) |=> $stable(flags_rdata[2:0]));

    // R6
    zero_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_rdata[CLR_HI:CLR_LO] == '0);

    // R7
    keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_flag_we |=> ($stable(flags_rdata[WORD_W-1:CLR_HI+1])
                           && $stable(flags_rdata[CLR_LO-1:NUM_FLAGS])));

    // R8
    zero_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cond_code[0] && flags_rdata[0]) || (cond_code[1] && !flags_rdata[0])) |-> !branch_take);

    // R9
    sel_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[3] && !(cond_code[4] ? flags_rdata[2] : flags_rdata[1])) |-> !branch_take);

    // R10
    no_demand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_code[3:0] == 4'b0000) |-> branch_take);

endmodule

bind ccf_unit ccf_unit_chk #(
    .WORD_W (WORD_W),
    .CLR_LO (CLR_LO),
    .CLR_HI (CLR_HI)
) u_chk (.*);

// File: tb/ccf_unit_bench.sv
`timescale 1ns/100ps
module ccf_unit_bench;

    localparam int WORD_W = 32;
    localparam int CLR_LO = 9;
    localparam int CLR_HI = 13;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              alu_flag_we;
    logic              alu_z, alu_c, alu_n;
    logic              host_flag_we;
    logic [WORD_W-1:0] host_flag_wdata;
    logic [4:0]        cond_code;
    logic              branch_take;
    logic [WORD_W-1:0] flags_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Model state
    logic              mz, mc, mn;
    logic [WORD_W-1:0] mkeep;

    always #2 clk = ~clk;

    ccf_unit u_ccf_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .alu_flag_we     (alu_flag_we),
        .alu_z           (alu_z),
        .alu_c           (alu_c),
        .alu_n           (alu_n),
        .host_flag_we    (host_flag_we),
        .host_flag_wdata (host_flag_wdata),
        .cond_code       (cond_code),
        .branch_take     (branch_take),
        .flags_rdata     (flags_rdata)
    );

    function automatic logic [WORD_W-1:0] keep_mask();
        logic [WORD_W-1:0] m = '0;
        for (int i = 3; i < WORD_W; i++)
            if (i < CLR_LO || i > CLR_HI) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic exp_take(logic [4:0] cc, logic z, logic c, logic n);
        logic sel = cc[4] ? n : c;
        logic t = 1'b1;
        if (cc[0] && z)    t = 1'b0;
        if (cc[1] && !z)   t = 1'b0;
        if (cc[2] && sel)  t = 1'b0;
        if (cc[3] && !sel) t = 1'b0;
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] exp_word();
        return (mkeep & keep_mask()) | {{(WORD_W-3){1'b0}}, mn, mc, mz};
    endfunction

    task automatic check(string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called in the low phase: check word and the taken bit for a given code.
    task automatic check_outputs(string req, logic [4:0] cc);
        cond_code = cc;
        #0.5;
        check(req, flags_rdata, exp_word());
        check(req, {31'b0, branch_take}, {31'b0, exp_take(cc, mz, mc, mn)});
    endtask

    // Drive one cycle of writes at the falling edge, update the model at the rising edge.
    task automatic cycle(logic awe, logic [2:0] af, logic hwe, logic [WORD_W-1:0] hd);
        alu_flag_we = awe; {alu_n, alu_c, alu_z} = af;
        host_flag_we = hwe; host_flag_wdata = hd;
        @(posedge clk);
        if (awe) {mn, mc, mz} = af;
        else if (hwe) {mn, mc, mz} = hd[2:0];
        if (hwe) mkeep = hd;
        @(negedge clk);
        alu_flag_we = 1'b0; host_flag_we = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst_n = 1'b0; alu_flag_we = 1'b0; host_flag_we = 1'b0;
        {alu_n, alu_c, alu_z} = 3'b111; host_flag_wdata = '1; cond_code = '0;
        mz = 0; mc = 0; mn = 0; mkeep = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, Z=0 so a Z=1 demand fails
        check_outputs("R1", 5'b00010);
        check_outputs("R1", 5'b00001);

        // R10 R8 R9: full sweep of codes for every flag combination via host writes
        for (int f = 0; f < 8; f++) begin
            cycle(1'b0, 3'b000, 1'b1, {{(WORD_W-3){1'b0}}, 3'(f)});
            for (int cc = 0; cc < 32; cc++) check_outputs("R8 R9 R10 R3", 5'(cc));
        end

        // R6 R7: all-ones host write, zero range stays zero
        cycle(1'b0, 3'b000, 1'b1, '1);
        check_outputs("R6 R7", 5'b10100);
        // R4 R7: both write, ALU wins flags, host owns upper bits
        cycle(1'b1, 3'b010, 1'b1, 32'hA5A5_5A5D);
        check_outputs("R4 R7", 5'b00100);
        // R2 R7: ALU update leaves upper bits alone
        cycle(1'b1, 3'b101, 1'b0, '0);
        check_outputs("R2 R7", 5'b11001);
        // R5 R11: idle cycle holds, decision reflects stored flags
        cycle(1'b0, 3'b010, 1'b0, '1);
        check_outputs("R5 R11", 5'b01010);

        // Random mix of writes and idle cycles
        for (int k = 0; k < 3000; k++) begin
            logic [2:0] sel = 3'($urandom_range(0, 7));
            cycle(sel[0], 3'($urandom), sel[1] & sel[2], $urandom);
            check_outputs("R2 R3 R4 R5 R7 R11", 5'($urandom));
        end

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(posedge clk); mz = 0; mc = 0; mn = 0; mkeep = '0;
        @(negedge clk); rst_n = 1'b1;
        check_outputs("R1", 5'b01000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule